// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

A passive observer for a four-bank synchronous DRAM command bus. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines into a command. It follows the state of each bank: idle, open, or running a burst that ends with an automatic precharge. It also keeps per-bank and bus-wide elapsed-time counters. A command that breaks a state rule or a minimum or maximum spacing rule raises an error.

Spacing is measured in nanoseconds. Each counter adds the configured clock period `tck_ns` once per cycle. A rule with a minimum of T ns therefore needs ceil(T / tck) clocks, and no divider is needed. Each error drives a one-cycle pulse, a code that names the rule, and the bank concerned. A sticky flag records that at least one error has occurred and stays set until reset. The monitor drives nothing onto the memory bus.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} as follows: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto-refresh, 0000 mode-register set, 0111 no-op, 0110 burst stop; cs_n high is deselect. `a_ap` high on a read or write requests auto-precharge, and on a precharge it selects every bank. Column commands to an open bank on consecutive clocks, once the activate-to-column gap is met, raise no error.
- R2: Reset is synchronous and active high, and it clears err_pulse, err_sticky, err_code and err_bank to 0. An error drives err_pulse for the one cycle after the offending edge and loads err_code and err_bank. err_sticky then stays 1 until reset, and err_code holds between errors.
- R3: Code 1 is raised by a mode-register set or auto-refresh while any bank is not idle. err_bank is the lowest such bank.
- R4: Code 2 is raised by any command other than no-op or deselect fewer than 2 clocks after a mode-register set. A mode-register set sets the burst length to 1, 2, 4 or 8 for a_mode values 0 to 3.
- R5: Code 3 is raised by an activate less than 15 ns after an activate to a different bank.
- R6: Code 4 is raised by a read or write to an open bank less than 20 ns after that bank's activate.
- R7: Code 5 is raised by an activate to an idle bank less than 20 ns after that bank's precharge began.
- R8: Code 6 is raised by an activate less than 65 ns after the previous activate to the same bank.
- R9: Code 7 is raised when a bank has been open for 100 µs. It is reported once per activation, with that bank's number.
- R10: Code 8 is raised by a read or write to a bank during its auto-precharge burst. The burst covers the burst-length clocks starting at the column command, after which the bank is idle.
- R11: Code 9 is raised by a precharge to an open bank less than 2 clocks after the last write data beat. The last beat falls burst length minus 1 clocks after the write.
- R12: Code 10 is raised by an activate to a bank that is not idle, or by a read or write to an idle bank.
- R13: A command is decoded only if cke was high at the previous clock edge; otherwise it is ignored.
- R14: When several rules break on one edge, the lowest code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge sampled |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable line of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a_ap | input | 1 | Auto-precharge / all-banks address line |
| a_mode | input | 2 | Low address bits carrying the burst-length field at mode set |
| tck_ns | input | 8 | Configured clock period in ns |
| err_pulse | output | 1 | One-cycle error strobe |
| err_sticky | output | 1 | Error seen since reset |
| err_code | output | 4 | Rule of the latest error |
| err_bank | output | 2 | Bank of the latest error |

## Verification
The bench places commands exactly one clock before and exactly on each rounded-up threshold. A counter that started one cycle late or compared with less-or-equal would pass the short gap or flag the legal one. It breaks the precharge and cycle-time rules on the same edge, so a wrong priority order shows up as code 6 instead of 5. It then leaves an auto-precharge burst and reissues a column command, where a design that closes the bank one cycle early or late reports the wrong code. It also holds a bank open past 100 µs, where a missing once-per-activation latch gives a pulse on every cycle. Finally it drops cke around illegal commands, which a monitor reading cke from the same edge would flag.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    C_NOP, C_DESEL, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST, C_OFF
  } cmd_e;

  typedef enum logic [1:0] {B_IDLE, B_OPEN, B_AP} bank_e;

  localparam logic [3:0] E_NONE  = 4'd0;
  localparam logic [3:0] E_OPEN  = 4'd1;
  localparam logic [3:0] E_MRD   = 4'd2;
  localparam logic [3:0] E_RRD   = 4'd3;
  localparam logic [3:0] E_RCD   = 4'd4;
  localparam logic [3:0] E_RP    = 4'd5;
  localparam logic [3:0] E_RC    = 4'd6;
  localparam logic [3:0] E_RAS   = 4'd7;
  localparam logic [3:0] E_APB   = 4'd8;
  localparam logic [3:0] E_WR    = 4'd9;
  localparam logic [3:0] E_STATE = 4'd10;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic en,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (!en)       cmd = C_OFF;
    else if (cs_n) cmd = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int TCK_W       = 8,
  parameter int TW          = 20,
  parameter int CW          = 5,
  parameter int TRAS_MAX_NS = 100000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TCK_W-1:0] tck,
  input  cmd_e             cmd,
  input  logic             hit,
  input  logic             a_ap,
  input  logic [3:0]       bl,
  output bank_e            st,
  output logic [TW-1:0]    t_act,
  output logic [TW-1:0]    t_pre,
  output logic [CW-1:0]    wr_cyc,
  output logic             ras_over
);
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [3:0] ap_left;
  logic       ras_done;
  logic       col;
  logic [TW-1:0] tck_x;

  assign tck_x = TW'(tck);
  assign col   = hit && (cmd == C_RD || cmd == C_WR);
  assign ras_over = (st == B_OPEN) && (t_act >= TW'(TRAS_MAX_NS)) && !ras_done;

  function automatic logic [TW-1:0] tadd(input logic [TW-1:0] t);
    logic [TW:0] s;
    s = {1'b0, t} + {1'b0, tck_x};
    return s[TW] ? TMAX : s[TW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      t_act    <= TMAX;
      t_pre    <= TMAX;
      wr_cyc   <= CMAX;
      ap_left  <= '0;
      ras_done <= 1'b0;
    end else begin
      t_act <= tadd(t_act);
      t_pre <= tadd(t_pre);
      if (wr_cyc != CMAX) wr_cyc <= wr_cyc + CW'(1);
      case (st)
        B_IDLE: if (cmd == C_ACT && hit) st <= B_OPEN;
        B_OPEN: begin
          if (cmd == C_PRE && (hit || a_ap)) begin
            st    <= B_IDLE;
            t_pre <= tck_x;
          end else if (col && a_ap) begin
            if (bl == 4'd1) begin
              st    <= B_IDLE;
              t_pre <= tck_x;
            end else begin
              st      <= B_AP;
              ap_left <= bl - 4'd1;
            end
          end
        end
        default: begin
          if (ap_left <= 4'd1) begin
            st    <= B_IDLE;
            t_pre <= tck_x;
          end else begin
            ap_left <= ap_left - 4'd1;
          end
        end
      endcase
      if (cmd == C_WR && hit) wr_cyc <= CW'(1);
      if (ras_over) ras_done <= 1'b1;
      if (cmd == C_ACT && hit) begin
        t_act    <= tck_x;
        ras_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BW        = 2,
  parameter int TW        = 20,
  parameter int CW        = 5,
  parameter int MW        = 2,
  parameter int T_RRD_NS  = 15,
  parameter int T_RCD_NS  = 20,
  parameter int T_RP_NS   = 20,
  parameter int T_RC_NS   = 65,
  parameter int T_MRD_CLK = 2,
  parameter int T_WR_CLK  = 2
) (
  input  cmd_e          cmd,
  input  logic [BW-1:0] ba,
  input  logic          a_ap,
  input  logic [3:0]    bl,
  input  bank_e         st     [NB],
  input  logic [TW-1:0] t_act  [NB],
  input  logic [TW-1:0] t_pre  [NB],
  input  logic [CW-1:0] wr_cyc [NB],
  input  logic [NB-1:0] ras_over,
  input  logic [TW-1:0] t_rrd,
  input  logic [BW-1:0] last_ba,
  input  logic [MW-1:0] mrs_cyc,
  output logic          hit,
  output logic [3:0]    code,
  output logic [BW-1:0] bank
);
  logic          real_cmd, col, any_open, wr_bad;
  logic [BW-1:0] open_b, ras_b, wr_b;
  logic [CW-1:0] wr_need;

  always_comb begin
    real_cmd = cmd inside {C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST};
    col      = (cmd == C_RD) || (cmd == C_WR);
    wr_need  = CW'(bl) + CW'(T_WR_CLK - 1);
    any_open = 1'b0; open_b = '0;
    ras_b    = '0;
    wr_bad   = 1'b0; wr_b = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (st[i] != B_IDLE) begin
        any_open = 1'b1;
        open_b   = BW'(i);
      end
      if (ras_over[i]) ras_b = BW'(i);
      if (st[i] == B_OPEN && (a_ap || ba == BW'(i)) && wr_cyc[i] < wr_need) begin
        wr_bad = 1'b1;
        wr_b   = BW'(i);
      end
    end

    hit  = 1'b1;
    bank = ba;
    if ((cmd == C_MRS || cmd == C_REF) && any_open) begin
      code = E_OPEN; bank = open_b;
    end else if (real_cmd && mrs_cyc < MW'(T_MRD_CLK)) begin
      code = E_MRD;
    end else if (cmd == C_ACT && ba != last_ba && t_rrd < TW'(T_RRD_NS)) begin
      code = E_RRD;
    end else if (col && st[ba] == B_OPEN && t_act[ba] < TW'(T_RCD_NS)) begin
      code = E_RCD;
    end else if (cmd == C_ACT && st[ba] == B_IDLE && t_pre[ba] < TW'(T_RP_NS)) begin
      code = E_RP;
    end else if (cmd == C_ACT && t_act[ba] < TW'(T_RC_NS)) begin
      code = E_RC;
    end else if (|ras_over) begin
      code = E_RAS; bank = ras_b;
    end else if (col && st[ba] == B_AP) begin
      code = E_APB;
    end else if (cmd == C_PRE && wr_bad) begin
      code = E_WR; bank = wr_b;
    end else if ((cmd == C_ACT && st[ba] != B_IDLE) || (col && st[ba] == B_IDLE)) begin
      code = E_STATE;
    end else begin
      code = E_NONE; hit = 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BW          = 2,
  parameter int TCK_W       = 8,
  parameter int TW          = 20,
  parameter int CW          = 5,
  parameter int T_RRD_NS    = 15,
  parameter int T_RCD_NS    = 20,
  parameter int T_RP_NS     = 20,
  parameter int T_RC_NS     = 65,
  parameter int TRAS_MAX_NS = 100000,
  parameter int T_MRD_CLK   = 2,
  parameter int T_WR_CLK    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BW-1:0]    ba,
  input  logic             a_ap,
  input  logic [1:0]       a_mode,
  input  logic [TCK_W-1:0] tck_ns,
  output logic             err_pulse,
  output logic             err_sticky,
  output logic [3:0]       err_code,
  output logic [BW-1:0]    err_bank
);
  localparam int NB = 1 << BW;
  localparam int MW = $clog2(T_MRD_CLK + 1);
  localparam logic [TW-1:0] TMAX = '1;

  cmd_e          cmd;
  logic          cke_q;
  logic [TW-1:0] t_rrd;
  logic [BW-1:0] last_ba;
  logic [MW-1:0] mrs_cyc;
  logic [3:0]    bl;
  bank_e         st     [NB];
  logic [TW-1:0] t_act  [NB];
  logic [TW-1:0] t_pre  [NB];
  logic [CW-1:0] wr_cyc [NB];
  logic [NB-1:0] ras_over;
  logic          hit;
  logic [3:0]    code;
  logic [BW-1:0] bank;
  logic [TW:0]   rrd_sum;

  sdram_cmd_decode u_dec (
    .en(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_track #(
      .TCK_W(TCK_W), .TW(TW), .CW(CW), .TRAS_MAX_NS(TRAS_MAX_NS)
    ) u_bank (
      .clk(clk), .rst(rst), .tck(tck_ns), .cmd(cmd), .hit(ba == BW'(g)),
      .a_ap(a_ap), .bl(bl), .st(st[g]), .t_act(t_act[g]), .t_pre(t_pre[g]),
      .wr_cyc(wr_cyc[g]), .ras_over(ras_over[g])
    );
  end

  sdram_rule_check #(
    .NB(NB), .BW(BW), .TW(TW), .CW(CW), .MW(MW),
    .T_RRD_NS(T_RRD_NS), .T_RCD_NS(T_RCD_NS), .T_RP_NS(T_RP_NS),
    .T_RC_NS(T_RC_NS), .T_MRD_CLK(T_MRD_CLK), .T_WR_CLK(T_WR_CLK)
  ) u_rule (
    .cmd(cmd), .ba(ba), .a_ap(a_ap), .bl(bl), .st(st), .t_act(t_act),
    .t_pre(t_pre), .wr_cyc(wr_cyc), .ras_over(ras_over), .t_rrd(t_rrd),
    .last_ba(last_ba), .mrs_cyc(mrs_cyc), .hit(hit), .code(code), .bank(bank)
  );

  assign rrd_sum = {1'b0, t_rrd} + (TW + 1)'(tck_ns);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q      <= 1'b1;
      t_rrd      <= TMAX;
      last_ba    <= '0;
      mrs_cyc    <= MW'(T_MRD_CLK);
      bl         <= 4'd1;
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
      err_code   <= 4'd0;
      err_bank   <= '0;
    end else begin
      cke_q <= cke;
      t_rrd <= rrd_sum[TW] ? TMAX : rrd_sum[TW-1:0];
      if (mrs_cyc < MW'(T_MRD_CLK)) mrs_cyc <= mrs_cyc + MW'(1);
      if (cmd == C_ACT) begin
        t_rrd   <= TW'(tck_ns);
        last_ba <= ba;
      end
      if (cmd == C_MRS) begin
        mrs_cyc <= MW'(1);
        bl      <= 4'd1 << a_mode;
      end
      err_pulse <= hit;
      if (hit) begin
        err_sticky <= 1'b1;
        err_code   <= code;
        err_bank   <= bank;
      end
    end
  end
endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       err_pulse,
  input logic       err_sticky,
  input logic [3:0] err_code
);
  p_reset_clears_r2: assert property (@(posedge clk)
    rst |=> (!err_sticky && !err_pulse && err_code == 4'd0));

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);

  p_pulse_sets_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_sticky);

  p_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> $stable(err_code));

  p_code_legal_r14: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_code != 4'd0 && err_code <= 4'd10));

  p_cke_ignore_r13: assert property (@(posedge clk) disable iff (rst)
    !cke |=> ##1 (!err_pulse || err_code == 4'd7));
endmodule

bind sdram_cmd_monitor sdram_mon_checker u_chk (
  .clk(clk), .rst(rst), .cke(cke), .err_pulse(err_pulse),
  .err_sticky(err_sticky), .err_code(err_code)
);

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  logic       clk = 1'b0, rst = 1'b1, cke = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0, a_mode = 2'd0;
  logic       a_ap = 1'b0;
  logic [7:0] tck_ns = 8'd8;
  logic       err_pulse, err_sticky;
  logic [3:0] err_code;
  logic [1:0] err_bank;
  int n_run = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [3:0] K_ACT = 4'b0011, K_RD = 4'b0101, K_WR = 4'b0100;
  localparam logic [3:0] K_PRE = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;
  localparam logic [3:0] K_NOP = 4'b0111;

  sdram_cmd_monitor u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a_ap(a_ap), .a_mode(a_mode), .tck_ns(tck_ns),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .err_code(err_code),
    .err_bank(err_bank)
  );

  always #4 clk = ~clk;

  task automatic drive(input logic [3:0] k, input logic [1:0] b, input logic ap, input logic [1:0] m);
    {cs_n, ras_n, cas_n, we_n} = k;
    ba = b; a_ap = ap; a_mode = m;
  endtask

  task automatic issue(input logic [3:0] k, input logic [1:0] b, input logic ap, input logic [1:0] m);
    drive(k, b, ap, m);
    @(negedge clk);
    drive(K_NOP, 2'd0, 1'b0, 2'd0);
  endtask

  task automatic nops(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cke = 1'b1;
    drive(K_NOP, 2'd0, 1'b0, 2'd0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_err(input string tag, input int code, input int bank);
    chk({tag, " pulse"}, err_pulse, 1);
    chk({tag, " code"}, err_code, code);
    chk({tag, " bank"}, err_bank, bank);
  endtask

  task automatic expect_quiet(input string tag);
    chk({tag, " no pulse"}, err_pulse, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset sticky", err_sticky, 0);
    chk("R2 reset pulse", err_pulse, 0);
    chk("R2 reset code", err_code, 0);
    chk("R2 reset bank", err_bank, 0);
  endtask

  task automatic t_legal();
    do_reset();
    issue(K_MRS, 2'd0, 1'b0, 2'd2); expect_quiet("R1 mode set");
    nops(1);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_quiet("R4 act two clocks after mode set");
    nops(2);
    issue(K_RD, 2'd0, 1'b0, 2'd0); expect_quiet("R1 read");
    issue(K_RD, 2'd0, 1'b0, 2'd0); expect_quiet("R1 back-to-back read");
    issue(K_WR, 2'd0, 1'b0, 2'd0); expect_quiet("R1 back-to-back write");
    chk("R1 sticky after legal flow", err_sticky, 0);
  endtask

  task automatic t_open_banks();
    do_reset();
    issue(K_ACT, 2'd2, 1'b0, 2'd0); nops(10);
    issue(K_MRS, 2'd0, 1'b0, 2'd0); expect_err("R3 mode set with bank open", 1, 2);
    do_reset();
    issue(K_ACT, 2'd1, 1'b0, 2'd0); nops(10);
    issue(K_REF, 2'd0, 1'b0, 2'd0); expect_err("R3 refresh with bank open", 1, 1);
  endtask

  task automatic t_mrd();
    do_reset();
    issue(K_MRS, 2'd0, 1'b0, 2'd0); expect_quiet("R4 mode set idle");
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_err("R4 command right after mode set", 2, 0);
  endtask

  task automatic t_rrd();
    do_reset();
    issue(K_ACT, 2'd2, 1'b0, 2'd0);
    issue(K_ACT, 2'd3, 1'b0, 2'd0); expect_err("R5 activate 8 ns after other bank", 3, 3);
    nops(1);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_quiet("R5 activate 16 ns after other bank");
  endtask

  task automatic t_rcd();
    do_reset();
    issue(K_ACT, 2'd1, 1'b0, 2'd0); nops(1);
    issue(K_RD, 2'd1, 1'b0, 2'd0); expect_err("R6 read 16 ns after activate", 4, 1);
    issue(K_RD, 2'd1, 1'b0, 2'd0); expect_quiet("R6 read 24 ns after activate");
  endtask

  task automatic t_rp();
    do_reset();
    issue(K_ACT, 2'd0, 1'b0, 2'd0); nops(2);
    issue(K_PRE, 2'd0, 1'b0, 2'd0); expect_quiet("R7 precharge");
    nops(1);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_err("R7 R14 activate 16 ns after precharge", 5, 0);
  endtask

  task automatic t_rc();
    do_reset();
    issue(K_ACT, 2'd0, 1'b0, 2'd0); nops(2);
    issue(K_PRE, 2'd0, 1'b0, 2'd0); nops(2);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_err("R8 activate 48 ns after activate", 6, 0);
    do_reset();
    issue(K_ACT, 2'd0, 1'b0, 2'd0); nops(2);
    issue(K_PRE, 2'd0, 1'b0, 2'd0); nops(5);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_quiet("R8 activate 72 ns after activate");
  endtask

  task automatic t_ras();
    int pulses;
    do_reset();
    issue(K_ACT, 2'd3, 1'b0, 2'd0);
    pulses = 0;
    for (int i = 0; i < 12490; i++) begin
      @(negedge clk);
      if (err_pulse) pulses++;
    end
    chk("R9 no flag before 100 us", pulses, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (err_pulse) pulses++;
    end
    chk("R9 single flag at 100 us", pulses, 1);
    chk("R9 code", err_code, 7);
    chk("R9 bank", err_bank, 3);
  endtask

  task automatic t_autopre();
    do_reset();
    issue(K_MRS, 2'd0, 1'b0, 2'd2); nops(1);
    issue(K_ACT, 2'd1, 1'b0, 2'd0); nops(2);
    issue(K_WR, 2'd1, 1'b1, 2'd0); expect_quiet("R10 write with auto-precharge");
    nops(2);
    issue(K_RD, 2'd1, 1'b0, 2'd0); expect_err("R10 read inside auto-precharge burst", 8, 1);
    nops(1);
    issue(K_RD, 2'd1, 1'b0, 2'd0); expect_err("R12 read after burst closed bank", 10, 1);
  endtask

  task automatic t_wr();
    do_reset();
    issue(K_MRS, 2'd0, 1'b0, 2'd2); nops(1);
    issue(K_ACT, 2'd2, 1'b0, 2'd0); nops(2);
    issue(K_WR, 2'd2, 1'b0, 2'd0); nops(3);
    issue(K_PRE, 2'd2, 1'b0, 2'd0); expect_err("R11 precharge 1 clock after last beat", 9, 2);
    do_reset();
    issue(K_MRS, 2'd0, 1'b0, 2'd2); nops(1);
    issue(K_ACT, 2'd2, 1'b0, 2'd0); nops(2);
    issue(K_WR, 2'd2, 1'b0, 2'd0); nops(4);
    issue(K_PRE, 2'd2, 1'b0, 2'd0); expect_quiet("R11 precharge 2 clocks after last beat");
    do_reset();
    issue(K_MRS, 2'd0, 1'b0, 2'd3); nops(1);
    issue(K_ACT, 2'd2, 1'b0, 2'd0); nops(2);
    issue(K_WR, 2'd2, 1'b0, 2'd0); nops(5);
    issue(K_PRE, 2'd2, 1'b0, 2'd0); expect_err("R4 R11 burst of 8 write recovery", 9, 2);
  endtask

  task automatic t_state();
    do_reset();
    issue(K_RD, 2'd0, 1'b0, 2'd0); expect_err("R12 read to idle bank", 10, 0);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); nops(9);
    issue(K_ACT, 2'd0, 1'b0, 2'd0); expect_err("R12 activate to open bank", 10, 0);
    nops(5);
    expect_quiet("R2 quiet after error");
    chk("R2 sticky held", err_sticky, 1);
    chk("R2 code held", err_code, 10);
  endtask

  task automatic t_cke();
    do_reset();
    cke = 1'b0;
    issue(K_NOP, 2'd0, 1'b0, 2'd0);
    issue(K_RD, 2'd0, 1'b0, 2'd0); expect_quiet("R13 read ignored with cke low");
    cke = 1'b1;
    issue(K_RD, 2'd0, 1'b0, 2'd0); expect_quiet("R13 read ignored on cke return");
    issue(K_NOP, 2'd0, 1'b0, 2'd0);
    chk("R13 sticky clear", err_sticky, 0);
    issue(K_RD, 2'd0, 1'b0, 2'd0); expect_err("R13 decode resumes", 10, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_legal();
    t_open_banks();
    t_mrd();
    t_rrd();
    t_rcd();
    t_rp();
    t_rc();
    t_autopre();
    t_wr();
    t_state();
    t_cke();
    t_ras();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule